// File: doc/BRIEF.md
# Single-digit decimal counter with seven-segment drive

This block holds one decimal digit. It steps through 0 to 9 on the rising edge of its clock and wraps back to 0. It decodes the digit straight onto the seven segment lines of a display position. An asynchronous reset returns the digit to zero. An inhibit input freezes the digit so that clock edges have no effect.

A display-enable input blanks the segment lines without stopping the count. A registered copy of that input comes out one clock later. Two decoded flags come out next to the segments. The carry flag is high for the lower half of the decade and low for the upper half. Its rising edge can clock the next digit of a chain of such blocks. The second flag goes low only while the digit is two.

Top module: `decade_seg_counter`

## Requirements
- R1: While `arst_i` is high the digit is 0 and `disp_en_o` is 0. The reset takes effect at once, without waiting for a clock edge, and the digit stays 0 for as long as reset is held.
- R2: With reset and inhibit low, each rising clock edge moves the digit from n to n+1 for n below 9, and from 9 to 0.
- R3: While `inhibit_i` is high at a rising edge, the digit keeps its value.
- R4: Reset wins over inhibit: with both high the digit is 0.
- R5: With `disp_en_i` high, `seg_o` is active high with bit 0 = a, bit 1 = b, bit 2 = c, bit 3 = d, bit 4 = e, bit 5 = f and bit 6 = g. The patterns are 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F (hex). Digit 6 lights segment a and digit 9 lights segment d.
- R6: With `disp_en_i` low, `seg_o` is all zero and the digit keeps counting as in R2 and R3.
- R7: `disp_en_o` equals the value `disp_en_i` had at the previous rising clock edge.
- R8: `div10_o` is 1 for digits 0 to 4 and 0 for digits 5 to 9.
- R9: `not_two_o` is 0 when the digit is 2 and 1 for every other digit.
- R10: `div10_o` and `not_two_o` do not depend on `disp_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock, rising edge |
| arst_i | input | 1 | Asynchronous reset, active high |
| inhibit_i | input | 1 | High: ignore clock edges |
| disp_en_i | input | 1 | High: drive segments, low: blank them |
| seg_o | output | 7 | Segment lines a..g in bits 0..6, active high |
| disp_en_o | output | 1 | Display enable delayed by one clock |
| div10_o | output | 1 | High for digits 0-4, low for 5-9 |
| not_two_o | output | 1 | Low only when the digit is 2 |

## Verification
The hardest case to reach from the ports is a reset that rises between clock edges while inhibit is also high. Both the asynchronous path and the priority of reset over inhibit have to show before any edge arrives. The stimulus raises both inputs just after a falling edge and samples the outputs a moment later, with no rising edge in between. It then holds reset across several edges. A second hard case is counting while blanked, since the segment lines then show nothing. The bench follows the digit through the two flags during blanked stretches, and it checks the segment pattern again once the display is enabled.

// File: rtl/dctr_pkg.sv
package dctr_pkg;
    localparam int DIGIT_W    = 4;
    localparam int LAST_DIGIT = 9;
    localparam int SEG_W      = 7;

    typedef struct packed {
        logic [DIGIT_W-1:0] digit;
        logic               en_dly;
    } dctr_state_t;

    // bit 0 = a ... bit 6 = g
    function automatic logic [SEG_W-1:0] seg_pattern(input logic [DIGIT_W-1:0] v);
        logic [SEG_W-1:0] p;
        case (v)
            4'd0:    p = 7'h3F;
            4'd1:    p = 7'h06;
            4'd2:    p = 7'h5B;
            4'd3:    p = 7'h4F;
            4'd4:    p = 7'h66;
            4'd5:    p = 7'h6D;
            4'd6:    p = 7'h7D;
            4'd7:    p = 7'h07;
            4'd8:    p = 7'h7F;
            4'd9:    p = 7'h6F;
            default: p = '0;
        endcase
        return p;
    endfunction
endpackage

// File: rtl/dctr_count.sv
module dctr_count
    import dctr_pkg::*;
(
    input  logic               clk_i,
    input  logic               arst_i,
    input  logic               inhibit_i,
    input  logic               en_i,
    output logic [DIGIT_W-1:0] digit_o,
    output logic               en_dly_o
);
    localparam logic [DIGIT_W-1:0] LAST_V = DIGIT_W'(LAST_DIGIT);

    dctr_state_t state_d, state_q;

    always_comb begin
        state_d        = state_q;
        state_d.en_dly = en_i;
        if (!inhibit_i) begin
            if (state_q.digit == LAST_V) state_d.digit = '0;
            else                         state_d.digit = state_q.digit + 1'b1;
        end
    end

    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i) state_q <= '0;
        else        state_q <= state_d;
    end

    assign digit_o  = state_q.digit;
    assign en_dly_o = state_q.en_dly;
endmodule

// File: rtl/dctr_segdec.sv
module dctr_segdec
    import dctr_pkg::*;
(
    input  logic [DIGIT_W-1:0] digit_i,
    input  logic               en_i,
    output logic [SEG_W-1:0]   seg_o
);
    logic [SEG_W-1:0] raw;

    always_comb begin
        raw   = seg_pattern(digit_i);
        seg_o = en_i ? raw : '0;
    end
endmodule

// File: rtl/dctr_flags.sv
module dctr_flags
    import dctr_pkg::*;
(
    input  logic [DIGIT_W-1:0] digit_i,
    output logic               div_o,
    output logic               not_two_o
);
    localparam logic [DIGIT_W-1:0] HALF_V = DIGIT_W'((LAST_DIGIT + 1) / 2);
    localparam logic [DIGIT_W-1:0] TWO_V  = DIGIT_W'(2);

    always_comb begin
        div_o     = (digit_i < HALF_V);
        not_two_o = (digit_i != TWO_V);
    end
endmodule

// File: rtl/decade_seg_counter.sv
module decade_seg_counter
    import dctr_pkg::*;
(
    input  logic             clk_i,
    input  logic             arst_i,
    input  logic             inhibit_i,
    input  logic             disp_en_i,
    output logic [SEG_W-1:0] seg_o,
    output logic             disp_en_o,
    output logic             div10_o,
    output logic             not_two_o
);
    logic [DIGIT_W-1:0] digit_q;

    dctr_count u_count (
        .clk_i     (clk_i),
        .arst_i    (arst_i),
        .inhibit_i (inhibit_i),
        .en_i      (disp_en_i),
        .digit_o   (digit_q),
        .en_dly_o  (disp_en_o)
    );

    dctr_segdec u_seg (
        .digit_i (digit_q),
        .en_i    (disp_en_i),
        .seg_o   (seg_o)
    );

    dctr_flags u_flags (
        .digit_i   (digit_q),
        .div_o     (div10_o),
        .not_two_o (not_two_o)
    );
endmodule

// File: rtl/dctr_checker.sv
module dctr_checker
    import dctr_pkg::*;
(
    input logic               clk_i,
    input logic               arst_i,
    input logic               inhibit_i,
    input logic               disp_en_i,
    input logic [DIGIT_W-1:0] digit,
    input logic [SEG_W-1:0]   seg_o,
    input logic               disp_en_o,
    input logic               div10_o,
    input logic               not_two_o
);
    p_range_r2: assert property (@(posedge clk_i) disable iff (arst_i)
        digit <= 4'd9);

    p_wrap_r2: assert property (@(posedge clk_i) disable iff (arst_i)
        (digit == 4'd9 && !inhibit_i) |=> (digit == 4'd0));

    p_step_r2: assert property (@(posedge clk_i) disable iff (arst_i)
        (digit < 4'd9 && !inhibit_i) |=> (digit == $past(digit) + 4'd1));

    p_hold_r3: assert property (@(posedge clk_i) disable iff (arst_i)
        inhibit_i |=> $stable(digit));

    p_blank_r6: assert property (@(posedge clk_i) disable iff (arst_i)
        !disp_en_i |-> (seg_o == '0));

    p_follow_r7: assert property (@(posedge clk_i) disable iff (arst_i)
        1'b1 |=> (disp_en_o == $past(disp_en_i)));

    p_carry_r8: assert property (@(posedge clk_i) disable iff (arst_i)
        $rose(div10_o) |-> (digit == 4'd0));

    p_two_r9: assert property (@(posedge clk_i) disable iff (arst_i)
        (!not_two_o && disp_en_i) |-> (seg_o == 7'h5B));
endmodule

bind decade_seg_counter dctr_checker u_chk (
    .clk_i     (clk_i),
    .arst_i    (arst_i),
    .inhibit_i (inhibit_i),
    .disp_en_i (disp_en_i),
    .digit     (digit_q),
    .seg_o     (seg_o),
    .disp_en_o (disp_en_o),
    .div10_o   (div10_o),
    .not_two_o (not_two_o)
);

// File: tb/tb_decade_seg_counter.sv
module tb_decade_seg_counter;
    localparam int CLK_P = 10;

    logic       clk_i = 1'b0;
    logic       arst_i = 1'b1;
    logic       inhibit_i = 1'b0;
    logic       disp_en_i = 1'b1;
    logic [6:0] seg_o;
    logic       disp_en_o, div10_o, not_two_o;

    int n_vec = 0;
    int n_bad = 0;
    int exp_digit = 0;
    logic exp_en = 1'b0;

    decade_seg_counter dut (
        .clk_i     (clk_i),
        .arst_i    (arst_i),
        .inhibit_i (inhibit_i),
        .disp_en_i (disp_en_i),
        .seg_o     (seg_o),
        .disp_en_o (disp_en_o),
        .div10_o   (div10_o),
        .not_two_o (not_two_o)
    );

    always #(CLK_P/2) clk_i = ~clk_i;

    // Segment membership by digit, each segment on its own
    function automatic logic [6:0] exp_seg(input int v, input logic en);
        logic [6:0] s;
        s[0] = !(v == 1 || v == 4);
        s[1] = !(v == 5 || v == 6);
        s[2] = (v != 2);
        s[3] = !(v == 1 || v == 4 || v == 7);
        s[4] = (v == 0 || v == 2 || v == 6 || v == 8);
        s[5] = !(v == 1 || v == 2 || v == 3 || v == 7);
        s[6] = !(v == 0 || v == 1 || v == 7);
        return en ? s : 7'h00;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (digit %0d)", req, act, exp, exp_digit);
        end
    endtask

    task automatic check_all();
        logic [6:0] s;
        s = exp_seg(exp_digit, disp_en_i);
        if (disp_en_i) chk(seg_o == s, "R5", int'(seg_o), int'(s));
        else           chk(seg_o == s, "R6", int'(seg_o), int'(s));
        chk(disp_en_o == exp_en, "R7", int'(disp_en_o), int'(exp_en));
        chk(div10_o == (exp_digit < 5), "R8 R10", int'(div10_o), int'(exp_digit < 5));
        chk(not_two_o == (exp_digit != 2), "R9 R10", int'(not_two_o), int'(exp_digit != 2));
    endtask

    task automatic step(input logic inh, input logic en);
        inhibit_i = inh;
        disp_en_i = en;
        @(posedge clk_i);
        if (!inh) exp_digit = (exp_digit == 9) ? 0 : exp_digit + 1;
        exp_en = en;
        @(negedge clk_i);
        check_all();
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk_i);
        // R1: reset state
        chk(seg_o == 7'h3F, "R1", int'(seg_o), 'h3F);
        chk(disp_en_o == 1'b0, "R1", int'(disp_en_o), 0);
        arst_i = 1'b0;
        check_all();

        // R2: plain counting, two full decades
        for (int i = 0; i < 22; i++) step(1'b0, 1'b1);

        // R3 R6 R7: sweep of inhibit and display enable
        for (int i = 0; i < 90; i++) step((i % 4) == 3, ((i / 3) % 3) != 0);

        // R6: a blanked decade, then enabled again
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0);
        step(1'b0, 1'b1);

        // R3: inhibit held across many edges
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1);

        // Move off zero, then R1 R4: reset with inhibit between edges
        step(1'b0, 1'b1);
        if (exp_digit == 0) step(1'b0, 1'b1);
        inhibit_i = 1'b1;
        arst_i    = 1'b1;
        #1;
        exp_digit = 0;
        chk(seg_o == 7'h3F, "R1 R4", int'(seg_o), 'h3F);
        chk(disp_en_o == 1'b0, "R1", int'(disp_en_o), 0);
        for (int i = 0; i < 3; i++) begin
            inhibit_i = (i != 1);
            @(negedge clk_i);
            chk(seg_o == 7'h3F, "R1 R4", int'(seg_o), 'h3F);
            chk(div10_o == 1'b1 && not_two_o == 1'b1, "R1", int'({div10_o, not_two_o}), 3);
        end
        arst_i = 1'b0;
        exp_en = 1'b0;
        check_all();
        step(1'b1, 1'b1);
        for (int i = 0; i < 12; i++) step(1'b0, (i % 2) == 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule